// File: doc/BRIEF.md
# PHY Management Register Model

This block stands in for the management register file of a single Ethernet PHY. It sits behind a host register port. The port exposes two 32-bit words: a command word and a data word. When the host writes the command word, the command runs at once. The command names a PHY address, a register number and a direction. A write command copies the data word into the selected PHY register. A read command loads the data word with the contents of the selected PHY register.

The model holds control and advertisement registers that can be written, and a status register whose link bit follows the `link_up` input. It also returns fixed identifier values and a fixed link-partner ability word. It matches only commands whose address equals `phy_addr`. Serial management timing and real auto-negotiation are not modelled. A register write to the control register with its reset bit set puts the control and advertisement registers back to their defaults and leaves the link bit as it is.

Top module: `phy_mgmt_regs`

## Requirements
- R1: A host write to the command word (`wr_sel`=0) stores the written value with bit 0 (busy) forced to 0. Reading back with `rd_sel`=0 returns the stored value.
- R2: The command word fields are: PHY address in bits 15:12, register number in bits 7:4, direction in bit 1 (1 = write to the PHY, 0 = read). A command runs on the clock edge that stores it, so a read result is in the data word (`rd_sel`=1) right after that edge.
- R3: A command whose address field differs from `phy_addr` leaves the data word and all PHY registers unchanged.
- R4: A write command to register 0 with data bit 15 clear stores the low 16 bits of the data word with bits 15 and 9 cleared.
- R5: After reset, register 0 reads 0x3100 (100 Mb/s bit 13, auto-negotiation bit 12, full duplex bit 8). A write command to register 0 with data bit 15 set reloads 0x3100 into register 0 and 0 into register 4, and keeps the link bit.
- R6: Register 1 reads 0xFE28 with bit 2 equal to `link_up` as sampled one clock earlier. The link bit is 0x0004.
- R7: Register 2 reads 0x0044, register 3 reads 0x1400 and register 5 reads 0x0DE0. Write commands to registers 1, 2, 3 and 5 change nothing.
- R8: A read command to any register numbered 6 to 15 loads the data word with zero.
- R9: Register 4 resets to 0. A write command to register 4 stores the low 16 bits of the data word, and a read command returns that value.
- R10: A host write to the data word (`wr_sel`=1) stores all 32 bits, and they read back with `rd_sel`=1.
- R11: A pulse on `soft_rst` clears the command and data words and reloads the register 0 and register 4 defaults.
- R12: After `rst_n` is released, the command and data words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset of all management state |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Word selected for the write: 0 = command, 1 = data |
| wr_data | input | 32 | Host write value |
| rd_sel | input | 1 | Word selected for the read: 0 = command, 1 = data |
| rd_data | output | 32 | Selected word, combinational |
| link_up | input | 1 | Link state from the line side |
| phy_addr | input | 4 | Address this PHY answers to |

## Verification
A wrong internal state always shows up in the data word. A bad control or advertisement value appears on the next read command to that register. A wrong link bit appears in a status read issued one cycle after the input changes. A command that was wrongly executed for another address shows up as a data word or register value that changed when it should not have. A missed default reload shows up as a non-default value on the first read after the reset bit or `soft_rst`. Every such fault is visible on `rd_data` one edge after the command that exposes it.

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs #(
  parameter int          DW         = 32,
  parameter int          AW         = 4,
  parameter logic [15:0] ID_HI      = 16'h0044,
  parameter logic [15:0] ID_LO      = 16'h1400,
  parameter logic [15:0] CTL_DEF    = 16'h3100,
  parameter logic [15:0] STAT_FIXED = 16'hFE28,
  parameter logic [15:0] PARTNER    = 16'h0DE0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          link_up,
  input  logic [AW-1:0] phy_addr
);
  localparam logic [15:0] CTL_CLR = 16'h8200;

  logic [DW-1:0] cmd_q, data_q;
  logic [15:0]   ctl_q, adv_q, rd_val;
  logic          link_q;

  wire          cmd_wr  = wr_en & ~wr_sel;
  wire          dat_wr  = wr_en &  wr_sel;
  wire [AW-1:0] c_addr  = wr_data[12 +: AW];
  wire [3:0]    c_reg   = wr_data[7:4];
  wire          c_write = wr_data[1];
  wire          hit     = cmd_wr && (c_addr == phy_addr);

  assign rd_data = rd_sel ? data_q : cmd_q;

  always_comb begin
    case (c_reg)
      4'd0:    rd_val = ctl_q;
      4'd1:    rd_val = STAT_FIXED | {13'd0, link_q, 2'b00};
      4'd2:    rd_val = ID_HI;
      4'd3:    rd_val = ID_LO;
      4'd4:    rd_val = adv_q;
      4'd5:    rd_val = PARTNER;
      default: rd_val = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      ctl_q  <= CTL_DEF;
      adv_q  <= '0;
    end else if (soft_rst) begin
      cmd_q  <= '0;
      data_q <= '0;
      ctl_q  <= CTL_DEF;
      adv_q  <= '0;
    end else begin
      if (dat_wr) data_q <= wr_data;
      if (cmd_wr) cmd_q  <= {wr_data[DW-1:1], 1'b0};
      if (hit && !c_write) data_q <= {{(DW-16){1'b0}}, rd_val};
      if (hit && c_write) begin
        case (c_reg)
          4'd0: begin
            if (data_q[15]) begin
              ctl_q <= CTL_DEF;
              adv_q <= '0;
            end else begin
              ctl_q <= data_q[15:0] & ~CTL_CLR;
            end
          end
          4'd4:    adv_q <= data_q[15:0];
          default: ;
        endcase
      end
    end
  end

  // R4: the self-clearing control bits never hold a one
  a_r4_ctl_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[15] == 1'b0) && (ctl_q[9] == 1'b0));

  // R3: a foreign address leaves everything alone
  a_r3_foreign_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !soft_rst && (c_addr != phy_addr)) |=>
      ($stable(ctl_q) && $stable(adv_q) && $stable(data_q)));

  // R7: write commands to read-only registers do not touch writable state
  a_r7_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && c_write && !soft_rst && (c_reg != 4'd0) && (c_reg != 4'd4)) |=>
      ($stable(ctl_q) && $stable(adv_q)));

  // R8: unsupported register numbers read as zero
  a_r8_unsup_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !c_write && !soft_rst && (c_reg > 4'd5)) |=> (data_q == '0));

  // R6: status word has its fixed bits regardless of link
  a_r6_status_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !c_write && !soft_rst && (c_reg == 4'd1)) |=>
      ((data_q & ~32'h4) == 32'h0000FE28));

  // R11: soft reset clears the host words and reloads control
  a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ((cmd_q == '0) && (data_q == '0) && (ctl_q == CTL_DEF) && (adv_q == '0)));

  // R1: busy bit of the stored command is never set
  a_r1_busy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (rd_sel || rd_data[0] == 1'b0) && (cmd_q[0] == 1'b0));
endmodule

// File: tb/phy_mgmt_regs_test.sv
module phy_mgmt_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        soft_rst = 0;
  logic        wr_en = 0;
  logic        wr_sel = 0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 0;
  logic [31:0] rd_data;
  logic        link_up = 1;
  logic [3:0]  phy_addr = 4'h3;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  typedef struct {
    logic        sel;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  phy_mgmt_regs uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .link_up(link_up), .phy_addr(phy_addr)
  );

  function automatic logic [31:0] mk(input logic [3:0] a, input logic [3:0] r,
                                     input logic w);
    return {16'h0, a, 4'h0, r, 2'b00, w, 1'b0};
  endfunction

  task automatic put(input logic sel, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic expect_word(input logic sel, input logic [31:0] v, input string req);
    item_t it;
    it.sel = sel; it.exp = v; it.req = req;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic phy_read(input logic [3:0] a, input logic [3:0] r,
                          input logic [31:0] v, input string req);
    put(0, mk(a, r, 0));
    expect_word(1, v, req);
  endtask

  task automatic phy_write(input logic [3:0] a, input logic [3:0] r, input logic [31:0] d);
    put(1, d);
    put(0, mk(a, r, 1));
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      wait (sb.size() > 0);
      @(negedge clk);
      it = sb[0];
      rd_sel = it.sel;
      #2;
      checks++;
      if (rd_data !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.req, rd_data, it.exp);
      end
      void'(sb.pop_front());
    end
  end

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual %0d expected <100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_word(0, 32'h0, "R12 cmd");
    expect_word(1, 32'h0, "R12 data");

    put(1, 32'h1234_5678);
    expect_word(1, 32'h1234_5678, "R10 data word");

    put(0, 32'hABCD_3013);
    expect_word(0, 32'hABCD_3012, "R1 busy cleared");
    expect_word(1, 32'h1234_5678, "R7 status write ignored");

    phy_read(4'h3, 4'd0, 32'h3100, "R2 R5 control default");
    phy_read(4'h3, 4'd1, 32'hFE2C, "R6 link up");
    link_up = 0;
    @(negedge clk);
    phy_read(4'h3, 4'd1, 32'hFE28, "R6 link down");
    phy_read(4'h3, 4'd2, 32'h0044, "R7 id high");
    phy_read(4'h3, 4'd3, 32'h1400, "R7 id low");
    phy_read(4'h3, 4'd5, 32'h0DE0, "R7 partner");
    phy_read(4'h3, 4'd6, 32'h0, "R8 reg6");
    phy_read(4'h3, 4'd15, 32'h0, "R8 reg15");

    phy_read(4'h3, 4'd4, 32'h0, "R9 adv default");
    phy_write(4'h3, 4'd4, 32'hFFFF_05E1);
    phy_read(4'h3, 4'd4, 32'h05E1, "R9 adv written");

    phy_write(4'h3, 4'd0, 32'hFFFF_7FFF);
    phy_read(4'h3, 4'd0, 32'h7DFF, "R4 control masked");

    phy_write(4'h5, 4'd4, 32'h0000_1111);
    phy_read(4'h3, 4'd4, 32'h05E1, "R3 foreign write");
    put(1, 32'hCAFE_0000);
    put(0, mk(4'h5, 4'd2, 0));
    expect_word(1, 32'hCAFE_0000, "R3 foreign read");

    phy_write(4'h3, 4'd2, 32'h0000_BEEF);
    phy_write(4'h3, 4'd5, 32'h0000_BEEF);
    phy_read(4'h3, 4'd2, 32'h0044, "R7 id after write");
    phy_read(4'h3, 4'd5, 32'h0DE0, "R7 partner after write");
    phy_read(4'h3, 4'd0, 32'h7DFF, "R7 control untouched");

    link_up = 1;
    @(negedge clk);
    phy_write(4'h3, 4'd0, 32'h0000_8000);
    phy_read(4'h3, 4'd0, 32'h3100, "R5 reset reload control");
    phy_read(4'h3, 4'd4, 32'h0, "R5 reset reload adv");
    phy_read(4'h3, 4'd1, 32'hFE2C, "R5 link kept");

    phy_write(4'h3, 4'd4, 32'h0000_0123);
    phy_write(4'h3, 4'd0, 32'h0000_0000);
    put(1, 32'h5555_AAAA);
    @(negedge clk);
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    expect_word(0, 32'h0, "R11 cmd cleared");
    expect_word(1, 32'h0, "R11 data cleared");
    phy_read(4'h3, 4'd4, 32'h0, "R11 adv default");
    phy_read(4'h3, 4'd0, 32'h3100, "R11 control default");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule